// File: doc/BRIEF.md
# Registered SDRAM Command Front End

This block is the command and address input stage of a registered memory module. It takes the chip selects, the row strobe, the column strobe, the write enable, the clock enable, a 12-bit address, a 2-bit bank address and one data-mask bit per byte lane from the host. It passes them on to the memory devices. A static strap input chooses how they travel. They either go through a one-cycle pipeline register or pass straight through in the same cycle.

Alongside the forwarded lines, the block decodes the forwarded control signals into a one-hot command word. It also produces qualifier outputs: the auto-precharge and precharge-all flags, a one-hot bank select, the row and column addresses, and the per-lane write mask and read high-impedance enables. The data-mask latency rules apply to those last two outputs. Because the decode works on the forwarded signals, every decoded output lines up in time with what the memory devices see.

Top module: `rdimm_cmd_frontend`

## Requirements
- R1: With `reg_en` high, every `mem_*` output equals the matching `in_*` input as captured on the previous rising edge. Before that edge, the `mem_*` outputs keep their old value.
- R2: With `reg_en` low, every `mem_*` output follows its `in_*` input within the same cycle, without waiting for a clock edge.
- R3: When all forwarded chip selects are high, only `cmd_onehot` bit 0 (inhibit) is set. In that case `auto_pre`, `pre_all`, `bank_hit`, `row_addr` and `col_addr` are all zero. Any single chip select that is low enables the decode.
- R4: When the block is selected, {ras_n,cas_n,we_n} decodes onto these `cmd_onehot` bits: 111 to bit 1 (NOP), 011 to bit 2 (ACTIVE), 101 to bit 3 (READ), 100 to bit 4 (WRITE), 110 to bit 5 (BURST TERMINATE), 010 to bit 6 (PRECHARGE) and 000 to bit 9 (LOAD MODE). Exactly one bit of `cmd_onehot` is set at any time.
- R5: The code 001 decodes to bit 7 (AUTO REFRESH) when the forwarded clock enable is high. It decodes to bit 8 (SELF REFRESH entry) when the forwarded clock enable is low.
- R6: On READ or WRITE, `auto_pre` equals address bit 10, `col_addr` equals address bits 8:0, and `bank_hit` is the one-hot decode of the bank address. For any other command, `auto_pre` is zero.
- R7: On PRECHARGE with address bit 10 high, `pre_all` is 1 and `bank_hit` is all ones, whatever the bank address. With bit 10 low, `pre_all` is 0 and `bank_hit` selects the addressed bank only.
- R8: On ACTIVE, `row_addr` equals all 12 address bits and `bank_hit` is the one-hot bank decode. For every other command, `row_addr` is zero. `col_addr` is zero for every command except READ and WRITE.
- R9: `wr_mask` equals the forwarded data mask with zero added latency.
- R10: `rd_hiz` equals the forwarded data mask from two rising edges earlier.
- R11: A low `rst_n` at a rising edge does two things. It loads the pipeline register with all chip selects high, the strobes high, the clock enable high, the address and bank at zero and all mask bits high. It also fills the read high-impedance delay line with ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Strap: 1 selects the pipelined path, 0 the flow-through path |
| in_cs_n | input | 2 | Host chip selects, active low |
| in_ras_n | input | 1 | Host row strobe, active low |
| in_cas_n | input | 1 | Host column strobe, active low |
| in_we_n | input | 1 | Host write enable, active low |
| in_cke | input | 1 | Host clock enable |
| in_addr | input | 12 | Host address |
| in_bank | input | 2 | Host bank address |
| in_dqm | input | 8 | Host per-lane data mask |
| mem_cs_n | output | 2 | Forwarded chip selects |
| mem_ras_n | output | 1 | Forwarded row strobe |
| mem_cas_n | output | 1 | Forwarded column strobe |
| mem_we_n | output | 1 | Forwarded write enable |
| mem_cke | output | 1 | Forwarded clock enable |
| mem_addr | output | 12 | Forwarded address |
| mem_bank | output | 2 | Forwarded bank address |
| mem_dqm | output | 8 | Forwarded data mask |
| cmd_onehot | output | 10 | Decoded command, one-hot |
| auto_pre | output | 1 | Auto precharge requested by READ/WRITE |
| pre_all | output | 1 | PRECHARGE applies to every bank |
| bank_hit | output | 4 | Banks targeted by the current command |
| row_addr | output | 12 | Row address of ACTIVE, else zero |
| col_addr | output | 9 | Start column of READ/WRITE, else zero |
| wr_mask | output | 8 | Per-lane write data mask, zero latency |
| rd_hiz | output | 8 | Per-lane read output disable, two cycles late |

## Verification
The bound checker covers several properties on every cycle. It checks the one-cycle relation between inputs and forwarded lines in pipelined mode, and the same-cycle equality in flow-through mode. It also checks that the command word is always one-hot, that inhibit follows the chip selects, that the refresh split follows the clock enable, how the precharge and auto-precharge flags relate to address bit 10, and the two-edge lag of the read high-impedance mask. Other behaviours can only be shown by the directed scenarios. These are the full decode table with its bit positions, the row and column extraction, the bank one-hot, the reset contents of the pipeline, and the point where an output must not yet have changed before an edge.

// File: rtl/rsd_pkg.sv
// Shared constants for the registered SDRAM command front end.
// Assumes the command word is one-hot with the bit positions below.
package rsd_pkg;
    localparam int NCMD     = 10;
    localparam int CMD_INH  = 0;
    localparam int CMD_NOP  = 1;
    localparam int CMD_ACT  = 2;
    localparam int CMD_RD   = 3;
    localparam int CMD_WR   = 4;
    localparam int CMD_BST  = 5;
    localparam int CMD_PRE  = 6;
    localparam int CMD_AREF = 7;
    localparam int CMD_SREF = 8;
    localparam int CMD_LMR  = 9;
endpackage

// File: rtl/rsd_stage.sv
// Pipeline-or-bypass stage for a flat control/address vector.
// Assumes reg_en is a static strap; switching it at run time is allowed
// but the output simply re-selects between the register and the input.
module rsd_stage #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Capture the host vector each edge; reset loads the idle pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= d;
    end

    // Pick the registered copy or the live input according to the strap.
    always_comb q = reg_en ? q_r : d;
endmodule

// File: rtl/rsd_cmd_decode.sv
// Combinational command decoder working on the forwarded control lines.
// Produces a one-hot command word and the per-command qualifiers.
// Assumes the block counts as selected when any chip select is low.
module rsd_cmd_decode
    import rsd_pkg::*;
#(
    parameter int NCS    = 2,
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int AP_BIT = 10,
    localparam int NBANK = 1 << BANK_W
) (
    input  logic [NCS-1:0]    cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              cke,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    output logic [NCMD-1:0]   cmd,
    output logic              auto_pre,
    output logic              pre_all,
    output logic [NBANK-1:0]  bank_hit,
    output logic [ADDR_W-1:0] row,
    output logic [COL_W-1:0]  col
);
    logic [NBANK-1:0] bank_dec;
    logic             is_rw;

    // Map the strobe pattern onto one command bit.
    always_comb begin
        cmd = '0;
        if (&cs_n) begin
            cmd[CMD_INH] = 1'b1;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd[CMD_NOP] = 1'b1;
                3'b011:  cmd[CMD_ACT] = 1'b1;
                3'b101:  cmd[CMD_RD]  = 1'b1;
                3'b100:  cmd[CMD_WR]  = 1'b1;
                3'b110:  cmd[CMD_BST] = 1'b1;
                3'b010:  cmd[CMD_PRE] = 1'b1;
                3'b001:  begin
                    if (cke) cmd[CMD_AREF] = 1'b1;
                    else     cmd[CMD_SREF] = 1'b1;
                end
                default: cmd[CMD_LMR] = 1'b1;
            endcase
        end
    end

    // One-hot decode of the bank field.
    always_comb begin
        bank_dec       = '0;
        bank_dec[bank] = 1'b1;
    end

    // Derive precharge flags, bank targets and the address split.
    always_comb begin
        is_rw    = cmd[CMD_RD] | cmd[CMD_WR];
        auto_pre = is_rw & addr[AP_BIT];
        pre_all  = cmd[CMD_PRE] & addr[AP_BIT];
        if (pre_all)
            bank_hit = '1;
        else if (is_rw | cmd[CMD_ACT] | cmd[CMD_PRE])
            bank_hit = bank_dec;
        else
            bank_hit = '0;
        row = cmd[CMD_ACT] ? addr : '0;
        col = is_rw ? addr[COL_W-1:0] : '0;
    end
endmodule

// File: rtl/rsd_dly.sv
// Fixed-depth delay line used for the read output-disable latency.
// Assumes DEPTH >= 1; every stage resets to RST_VAL.
module rsd_dly #(
    parameter int           W       = 8,
    parameter int           DEPTH   = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stg
            if (i == 0) begin : g_head
                // First stage samples the input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_tail
                // Later stages shift the previous stage along.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= RST_VAL;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/rdimm_cmd_frontend.sv
// Command/address front end of a registered memory module.
// Forwards host control lines through a strap-selected register or bypass,
// then decodes the forwarded lines and applies the data-mask latencies.
// Assumes reg_en is tied off per board; the reset is synchronous, active low.
module rdimm_cmd_frontend
    import rsd_pkg::*;
#(
    parameter int NCS     = 2,
    parameter int ADDR_W  = 12,
    parameter int BANK_W  = 2,
    parameter int LANES   = 8,
    parameter int COL_W   = 9,
    parameter int AP_BIT  = 10,
    parameter int HIZ_LAT = 2,
    localparam int NBANK  = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic [NCS-1:0]    in_cs_n,
    input  logic              in_ras_n,
    input  logic              in_cas_n,
    input  logic              in_we_n,
    input  logic              in_cke,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BANK_W-1:0] in_bank,
    input  logic [LANES-1:0]  in_dqm,
    output logic [NCS-1:0]    mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_cke,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BANK_W-1:0] mem_bank,
    output logic [LANES-1:0]  mem_dqm,
    output logic [NCMD-1:0]   cmd_onehot,
    output logic              auto_pre,
    output logic              pre_all,
    output logic [NBANK-1:0]  bank_hit,
    output logic [ADDR_W-1:0] row_addr,
    output logic [COL_W-1:0]  col_addr,
    output logic [LANES-1:0]  wr_mask,
    output logic [LANES-1:0]  rd_hiz
);
    localparam int VEC_W = NCS + 4 + ADDR_W + BANK_W + LANES;
    localparam logic [VEC_W-1:0] IDLE_VEC =
        {{NCS{1'b1}}, 4'b1111, {ADDR_W{1'b0}}, {BANK_W{1'b0}}, {LANES{1'b1}}};

    logic [VEC_W-1:0] host_vec;
    logic [VEC_W-1:0] fwd_vec;

    // Pack the host lines into one vector for the stage.
    always_comb host_vec = {in_cs_n, in_ras_n, in_cas_n, in_we_n, in_cke,
                            in_addr, in_bank, in_dqm};

    rsd_stage #(.W(VEC_W), .RST_VAL(IDLE_VEC)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .reg_en (reg_en),
        .d      (host_vec),
        .q      (fwd_vec)
    );

    // Unpack the forwarded vector onto the memory-side pins.
    always_comb {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_cke,
                 mem_addr, mem_bank, mem_dqm} = fwd_vec;

    rsd_cmd_decode #(
        .NCS(NCS), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
        .COL_W(COL_W), .AP_BIT(AP_BIT)
    ) u_dec (
        .cs_n     (mem_cs_n),
        .ras_n    (mem_ras_n),
        .cas_n    (mem_cas_n),
        .we_n     (mem_we_n),
        .cke      (mem_cke),
        .addr     (mem_addr),
        .bank     (mem_bank),
        .cmd      (cmd_onehot),
        .auto_pre (auto_pre),
        .pre_all  (pre_all),
        .bank_hit (bank_hit),
        .row      (row_addr),
        .col      (col_addr)
    );

    // Write masking acts on the same cycle as the forwarded mask.
    always_comb wr_mask = mem_dqm;

    rsd_dly #(.W(LANES), .DEPTH(HIZ_LAT), .RST_VAL({LANES{1'b1}})) u_hiz (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (mem_dqm),
        .q     (rd_hiz)
    );
endmodule

// File: rtl/rsd_checker.sv
// Property checker for rdimm_cmd_frontend, attached by bind below.
// Assumes the read disable lag is fixed at two edges (default build).
module rsd_checker
    import rsd_pkg::*;
#(
    parameter int NCS    = 2,
    parameter int ADDR_W = 12,
    parameter int BANK_W = 2,
    parameter int LANES  = 8,
    parameter int AP_BIT = 10,
    localparam int NBANK = 1 << BANK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              in_ras_n,
    input logic [ADDR_W-1:0] in_addr,
    input logic              mem_ras_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [NCS-1:0]    mem_cs_n,
    input logic              mem_cke,
    input logic [LANES-1:0]  mem_dqm,
    input logic [NCMD-1:0]   cmd_onehot,
    input logic              auto_pre,
    input logic              pre_all,
    input logic [NBANK-1:0]  bank_hit,
    input logic [LANES-1:0]  rd_hiz
);
    // R1: pipelined mode shows last edge's inputs.
    a_r1_reg_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_en && $past(rst_n)) |->
        (mem_ras_n == $past(in_ras_n) && mem_addr == $past(in_addr)));

    // R2: flow-through mode matches live inputs.
    a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_en |-> (mem_addr == in_addr && mem_ras_n == in_ras_n));

    // R3: deselect yields inhibit.
    a_r3_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        (&mem_cs_n) |-> (cmd_onehot[CMD_INH] && bank_hit == '0));

    // R4: command word is one-hot.
    a_r4_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cmd_onehot) == 1);

    // R5: refresh split follows clock enable.
    a_r5_refresh_split: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_onehot[CMD_AREF] |-> mem_cke) and (cmd_onehot[CMD_SREF] |-> !mem_cke));

    // R6: auto precharge only on READ/WRITE with bit 10 set.
    a_r6_auto_pre: assert property (@(posedge clk) disable iff (!rst_n)
        auto_pre |-> ((cmd_onehot[CMD_RD] || cmd_onehot[CMD_WR]) && mem_addr[AP_BIT]));

    // R7: precharge-all hits every bank.
    a_r7_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> (cmd_onehot[CMD_PRE] && bank_hit == '1));

    // R10: read disable lags the forwarded mask by two edges.
    a_r10_hiz_lag: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> rd_hiz == $past(mem_dqm, 2));
endmodule

bind rdimm_cmd_frontend rsd_checker #(
    .NCS(NCS), .ADDR_W(ADDR_W), .BANK_W(BANK_W), .LANES(LANES), .AP_BIT(AP_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_en     (reg_en),
    .in_ras_n   (in_ras_n),
    .in_addr    (in_addr),
    .mem_ras_n  (mem_ras_n),
    .mem_addr   (mem_addr),
    .mem_cs_n   (mem_cs_n),
    .mem_cke    (mem_cke),
    .mem_dqm    (mem_dqm),
    .cmd_onehot (cmd_onehot),
    .auto_pre   (auto_pre),
    .pre_all    (pre_all),
    .bank_hit   (bank_hit),
    .rd_hiz     (rd_hiz)
);

// File: tb/tb_rdimm_cmd_frontend.sv
`timescale 1ns/1ps
module tb_rdimm_cmd_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b1;
    logic [1:0]  in_cs_n = 2'b11;
    logic        in_ras_n = 1'b1, in_cas_n = 1'b1, in_we_n = 1'b1, in_cke = 1'b1;
    logic [11:0] in_addr = '0;
    logic [1:0]  in_bank = '0;
    logic [7:0]  in_dqm = '1;
    logic [1:0]  mem_cs_n;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_cke;
    logic [11:0] mem_addr;
    logic [1:0]  mem_bank;
    logic [7:0]  mem_dqm;
    logic [9:0]  cmd_onehot;
    logic        auto_pre, pre_all;
    logic [3:0]  bank_hit;
    logic [11:0] row_addr;
    logic [8:0]  col_addr;
    logic [7:0]  wr_mask, rd_hiz;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    rdimm_cmd_frontend dut (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en),
        .in_cs_n(in_cs_n), .in_ras_n(in_ras_n), .in_cas_n(in_cas_n),
        .in_we_n(in_we_n), .in_cke(in_cke), .in_addr(in_addr),
        .in_bank(in_bank), .in_dqm(in_dqm),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_cke(mem_cke), .mem_addr(mem_addr),
        .mem_bank(mem_bank), .mem_dqm(mem_dqm), .cmd_onehot(cmd_onehot),
        .auto_pre(auto_pre), .pre_all(pre_all), .bank_hit(bank_hit),
        .row_addr(row_addr), .col_addr(col_addr), .wr_mask(wr_mask),
        .rd_hiz(rd_hiz)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one command pattern onto the host side.
    task automatic put(input logic [1:0] cs, input logic [2:0] rcw, input logic cke,
                       input logic [11:0] a, input logic [1:0] b, input logic [7:0] m);
        in_cs_n = cs;
        {in_ras_n, in_cas_n, in_we_n} = rcw;
        in_cke = cke; in_addr = a; in_bank = b; in_dqm = m;
    endtask

    // Expected one-hot per R3/R4/R5 table.
    function automatic logic [9:0] exp_cmd(input logic [1:0] cs, input logic [2:0] rcw,
                                           input logic cke);
        if (cs == 2'b11) return 10'd1;
        case (rcw)
            3'b111: return 10'd1 << 1;
            3'b011: return 10'd1 << 2;
            3'b101: return 10'd1 << 3;
            3'b100: return 10'd1 << 4;
            3'b110: return 10'd1 << 5;
            3'b010: return 10'd1 << 6;
            3'b001: return cke ? (10'd1 << 7) : (10'd1 << 8);
            default: return 10'd1 << 9;
        endcase
    endfunction

    task automatic t_reset;
        reg_en = 1'b1;
        rst_n = 1'b0;
        put(2'b00, 3'b011, 1'b0, 12'hABC, 2'd3, 8'h00);
        @(negedge clk); @(negedge clk);
        check("R11", "cs_n", mem_cs_n, 2'b11);
        check("R11", "cke", mem_cke, 1'b1);
        check("R11", "dqm", mem_dqm, 8'hFF);
        check("R11", "addr", mem_addr, 12'h000);
        check("R11", "rd_hiz", rd_hiz, 8'hFF);
        check("R3", "cmd after reset", cmd_onehot, 10'd1);
        put(2'b11, 3'b111, 1'b1, 12'h000, 2'd0, 8'hFF);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reg_decode;
        reg_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            logic [2:0] rcw;
            rcw = 3'(k);
            put(2'b10, rcw, 1'b1, 12'h155, 2'd1, 8'h00);
            #1;
            check("R1", "not yet forwarded", mem_ras_n, 1'b1);
            @(negedge clk);
            check("R4", "reg decode", cmd_onehot, exp_cmd(2'b10, rcw, 1'b1));
            check("R1", "ras forwarded", mem_ras_n, rcw[2]);
            put(2'b11, 3'b111, 1'b1, 12'h000, 2'd0, 8'h00);
            @(negedge clk);
        end
    endtask

    task automatic t_bypass;
        reg_en = 1'b0;
        put(2'b01, 3'b100, 1'b1, 12'h3C7, 2'd2, 8'h11);
        #1;
        check("R2", "addr same cycle", mem_addr, 12'h3C7);
        check("R2", "bank same cycle", mem_bank, 2'd2);
        check("R4", "bypass write", cmd_onehot, 10'd1 << 4);
        put(2'b00, 3'b000, 1'b1, 12'h032, 2'd0, 8'h00);
        #1;
        check("R4", "bypass load mode", cmd_onehot, 10'd1 << 9);
        @(negedge clk);
        reg_en = 1'b1;
    endtask

    task automatic t_refresh;
        reg_en = 1'b1;
        put(2'b10, 3'b001, 1'b1, 12'h000, 2'd0, 8'h00);
        @(negedge clk);
        check("R5", "auto refresh", cmd_onehot, 10'd1 << 7);
        put(2'b10, 3'b001, 1'b0, 12'h000, 2'd0, 8'h00);
        @(negedge clk);
        check("R5", "self refresh", cmd_onehot, 10'd1 << 8);
    endtask

    task automatic t_rw_flags;
        reg_en = 1'b1;
        put(2'b10, 3'b101, 1'b1, 12'h5A5, 2'd1, 8'h00);
        @(negedge clk);
        check("R6", "read auto_pre", auto_pre, 1'b1);
        check("R6", "read col", col_addr, 9'h1A5);
        check("R6", "read bank", bank_hit, 4'b0010);
        check("R8", "read row zero", row_addr, 12'h000);
        put(2'b10, 3'b100, 1'b1, 12'h1FF, 2'd3, 8'h00);
        @(negedge clk);
        check("R6", "write no auto_pre", auto_pre, 1'b0);
        check("R6", "write col", col_addr, 9'h1FF);
        check("R6", "write bank", bank_hit, 4'b1000);
        put(2'b10, 3'b011, 1'b1, 12'h400, 2'd0, 8'h00);
        @(negedge clk);
        check("R6", "active ignores bit10 for auto_pre", auto_pre, 1'b0);
    endtask

    task automatic t_precharge;
        reg_en = 1'b1;
        put(2'b10, 3'b010, 1'b1, 12'h400, 2'd2, 8'h00);
        @(negedge clk);
        check("R7", "pre_all set", pre_all, 1'b1);
        check("R7", "all banks", bank_hit, 4'b1111);
        put(2'b10, 3'b010, 1'b1, 12'h000, 2'd2, 8'h00);
        @(negedge clk);
        check("R7", "single pre_all", pre_all, 1'b0);
        check("R7", "single bank", bank_hit, 4'b0100);
    endtask

    task automatic t_active;
        reg_en = 1'b1;
        put(2'b01, 3'b011, 1'b1, 12'hABC, 2'd3, 8'h00);
        @(negedge clk);
        check("R8", "row", row_addr, 12'hABC);
        check("R8", "col zero", col_addr, 9'h000);
        check("R8", "bank", bank_hit, 4'b1000);
    endtask

    task automatic t_inhibit;
        reg_en = 1'b1;
        put(2'b11, 3'b010, 1'b1, 12'h400, 2'd1, 8'h00);
        @(negedge clk);
        check("R3", "inhibit cmd", cmd_onehot, 10'd1);
        check("R3", "inhibit pre_all", pre_all, 1'b0);
        check("R3", "inhibit bank", bank_hit, 4'b0000);
        check("R3", "inhibit row", row_addr, 12'h000);
    endtask

    task automatic t_dqm;
        reg_en = 1'b1;
        put(2'b11, 3'b111, 1'b1, 12'h000, 2'd0, 8'hFF);
        repeat (3) @(negedge clk);
        put(2'b10, 3'b100, 1'b1, 12'h000, 2'd0, 8'h5A);
        @(negedge clk);
        check("R9", "write mask now", wr_mask, 8'h5A);
        put(2'b10, 3'b111, 1'b1, 12'h000, 2'd0, 8'h00);
        @(negedge clk);
        check("R10", "hiz one edge", rd_hiz, 8'hFF);
        @(negedge clk);
        check("R10", "hiz two edges", rd_hiz, 8'h5A);
        @(negedge clk);
        check("R10", "hiz next", rd_hiz, 8'h00);
        reg_en = 1'b0;
        put(2'b10, 3'b100, 1'b1, 12'h000, 2'd0, 8'h3C);
        #1;
        check("R9", "bypass write mask", wr_mask, 8'h3C);
        @(negedge clk);
        reg_en = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_reg_decode();
        t_bypass();
        t_refresh();
        t_rw_flags();
        t_precharge();
        t_active();
        t_inhibit();
        t_dqm();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule